// File: doc/BRIEF.md
# I2C Byte Segment Counter

This block tracks how many bytes remain in an I2C transfer and decides what happens on the final byte. Software or a higher-level controller loads an 8-bit count and pulses a start strobe. The byte engine then pulses `byte_done` once for each byte that completes. When one byte is left, the block flags it. In master receive that flag becomes a request to NACK. When the count is used up, the block either asks for a fresh count, which allows transfers longer than 255 bytes, or ends the transfer. It ends the transfer with a STOP request, or it holds a completion flag and waits for a STOP or RESTART command.

The mode input is `00` master transmit, `01` master receive, `10` plain slave and `11` SMBus slave. In plain slave mode the counter is not used. In SMBus slave mode the counter controls the ACK of each byte and the PEC reception, and the block never asks for a STOP. Mode, auto-stop, PEC enable and reload enable are captured when a segment starts. A reload write captures a new count and a new reload enable.

The controller has five states:
- `ST_IDLE` waits for a start.
- `ST_RUN` counts bytes.
- `ST_RELOAD` waits for a new count.
- `ST_HOLD` reports a finished transfer and waits for a command.
- `ST_END` is one cycle that ends the transfer.

The transitions are:
- IDLE→RUN on a valid start.
- RUN→RUN on each byte that is not the last one.
- RUN→RELOAD on the final byte with reload on.
- RUN→END on the final byte with auto-stop, or always in SMBus slave mode.
- RUN→HOLD on the final byte without auto-stop.
- RELOAD→RUN on a valid reload write.
- HOLD→END on a stop command.
- HOLD→RUN on a restart, which is a valid start.
- END→IDLE unconditionally.

Top module: `i2c_seg_counter`

## Requirements
- R1: After reset every output is low and the block is idle.
- R2: A start with a count N from 1 to 255 in modes `00`, `01` or `11` begins a segment of exactly N `byte_done` strobes. `last_byte` is high from after the (N-1)th strobe until the Nth strobe, and only when reload is off for that segment.
- R3: A start or a reload write with a count of zero pulses `cfg_err` high for one cycle. It begins nothing: later strobes do not raise `last_byte`, `xfer_done` or `reload_req`.
- R4: In plain slave mode (`10`) a start is ignored. No output rises, including after strobes.
- R5: `nack_next` equals `last_byte` when the segment's mode is master receive (`01`), and is low in every other mode.
- R6: Ending a segment with reload on raises `reload_req`. While it is high, `byte_done` is ignored. A reload write with a nonzero count loads that count and the new reload enable, and drops `reload_req`. A `byte_done` in the same cycle as the reload write is also ignored.
- R7: In master modes with auto-stop set, the final strobe leads to exactly one cycle with both `xfer_done` and `stop_req` high, followed by idle.
- R8: In master modes without auto-stop, `xfer_done` stays high with `stop_req` low until a command arrives. A `cmd_stop` gives the R7 cycle. A start (restart) gives a one-cycle `restart_req` and a new segment. If both arrive in the same cycle, the stop wins.
- R9: In SMBus slave mode `ack_next` is high while bytes are being counted. The end gives one cycle of `xfer_done` with `stop_req` low, whatever auto-stop is set to.
- R10: `pec_byte` equals `last_byte` when PEC was enabled at start, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_count | input | CNT_W | Byte count for a start or reload write |
| cfg_reload_en | input | 1 | Segment ends in a reload request |
| cfg_autostop | input | 1 | Master ends with STOP automatically |
| cfg_mode | input | 2 | 00 master tx, 01 master rx, 10 slave, 11 SMBus slave |
| cfg_pec_en | input | 1 | Final byte is the PEC byte |
| seg_start | input | 1 | Start (or restart from hold) strobe |
| byte_done | input | 1 | One byte completed |
| reload_wr | input | 1 | New count written during reload wait |
| cmd_stop | input | 1 | Stop command during hold |
| last_byte | output | 1 | Next byte is the final one |
| nack_next | output | 1 | NACK the next received byte |
| ack_next | output | 1 | SMBus slave ACKs the next byte |
| pec_byte | output | 1 | Next byte is the PEC byte |
| reload_req | output | 1 | Waiting for a new count |
| xfer_done | output | 1 | Transfer count exhausted |
| stop_req | output | 1 | Issue STOP now |
| restart_req | output | 1 | One-cycle pulse on a restart |
| cfg_err | output | 1 | One-cycle pulse on a zero count |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is a byte strobe and a reload write, both arriving while the block waits for a new count. The bench drives them together. It then checks that `last_byte` is high at once for a new count of one. That shows the strobe did not use up the new segment, and exactly one further strobe must then end the transfer.

The second pair is a stop command and a restart, both arriving during hold. The bench drives them together. It expects `stop_req` with no `restart_req`, followed by idle.

// File: rtl/i2c_seg_pkg.sv
package i2c_seg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_RELOAD = 3'd2,
        ST_HOLD   = 3'd3,
        ST_END    = 3'd4
    } seg_state_e;

    typedef enum logic [1:0] {
        MD_MTX = 2'b00,
        MD_MRX = 2'b01,
        MD_SLV = 2'b10,
        MD_SMB = 2'b11
    } seg_mode_e;

endpackage

// File: rtl/i2c_seg_cnt.sv
module i2c_seg_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - ONE;
        end
    end

    assign at_one = (remain == ONE);

    AST_DEC_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remain > ONE)); // R2
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R3

endmodule

// File: rtl/i2c_seg_fsm.sv
module i2c_seg_fsm
    import i2c_seg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_reload_en,
    input  logic             cfg_autostop,
    input  seg_mode_e        cfg_mode,
    input  logic             cfg_pec_en,
    input  logic             seg_start,
    input  logic             byte_done,
    input  logic             reload_wr,
    input  logic             cmd_stop,
    input  logic             at_one,
    output seg_state_e       state,
    output logic             load,
    output logic             dec,
    output seg_mode_e        mode_q,
    output logic             pec_q,
    output logic             reload_q,
    output logic             err_q,
    output logic             restart_q
);
    seg_state_e nxt;
    logic       count_nz;
    logic       start_ok;
    logic       autostop_q;
    logic       latch_cfg;
    logic       latch_rl;
    logic       err_set;
    logic       rst_set;

    assign count_nz = (cfg_count != '0);
    assign start_ok = seg_start && (cfg_mode != MD_SLV);

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        dec       = 1'b0;
        latch_cfg = 1'b0;
        latch_rl  = 1'b0;
        err_set   = 1'b0;
        rst_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    if (count_nz) begin
                        load      = 1'b1;
                        latch_cfg = 1'b1;
                        nxt       = ST_RUN;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (byte_done) begin
                    if (!at_one)              dec = 1'b1;
                    else if (reload_q)        nxt = ST_RELOAD;
                    else if (mode_q == MD_SMB) nxt = ST_END;
                    else if (autostop_q)      nxt = ST_END;
                    else                      nxt = ST_HOLD;
                end
            end
            ST_RELOAD: begin
                if (reload_wr) begin
                    if (count_nz) begin
                        load     = 1'b1;
                        latch_rl = 1'b1;
                        nxt      = ST_RUN;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (cmd_stop) begin
                    nxt = ST_END;
                end else if (start_ok) begin
                    if (count_nz) begin
                        load      = 1'b1;
                        latch_cfg = 1'b1;
                        rst_set   = 1'b1;
                        nxt       = ST_RUN;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            ST_END:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mode_q     <= MD_MTX;
            pec_q      <= 1'b0;
            reload_q   <= 1'b0;
            autostop_q <= 1'b0;
            err_q      <= 1'b0;
            restart_q  <= 1'b0;
        end else begin
            state     <= nxt;
            err_q     <= err_set;
            restart_q <= rst_set;
            if (latch_cfg) begin
                mode_q     <= cfg_mode;
                pec_q      <= cfg_pec_en;
                autostop_q <= cfg_autostop;
            end
            if (latch_cfg || latch_rl) begin
                reload_q <= cfg_reload_en;
            end
        end
    end

    AST_RELOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELOAD && !reload_wr) |=> (state == ST_RELOAD)); // R6
    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cmd_stop && !seg_start) |=> (state == ST_HOLD)); // R8
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state == $past(state))); // R3
    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |=> (state == ST_IDLE)); // R7

endmodule

// File: rtl/i2c_seg_flags.sv
module i2c_seg_flags
    import i2c_seg_pkg::*;
(
    input  seg_state_e state,
    input  logic       at_one,
    input  seg_mode_e  mode_q,
    input  logic       pec_q,
    input  logic       reload_q,
    output logic       last_byte,
    output logic       nack_next,
    output logic       ack_next,
    output logic       pec_byte,
    output logic       reload_req,
    output logic       xfer_done,
    output logic       stop_req
);
    logic master;

    assign master = (mode_q == MD_MTX) || (mode_q == MD_MRX);

    always_comb begin
        last_byte  = 1'b0;
        nack_next  = 1'b0;
        ack_next   = 1'b0;
        pec_byte   = 1'b0;
        reload_req = 1'b0;
        xfer_done  = 1'b0;
        stop_req   = 1'b0;
        unique case (state)
            ST_RUN: begin
                last_byte = at_one && !reload_q;
                nack_next = at_one && !reload_q && (mode_q == MD_MRX);
                pec_byte  = at_one && !reload_q && pec_q;
                ack_next  = (mode_q == MD_SMB);
            end
            ST_RELOAD: reload_req = 1'b1;
            ST_HOLD:   xfer_done  = 1'b1;
            ST_END: begin
                xfer_done = 1'b1;
                stop_req  = master;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_seg_counter.sv
module i2c_seg_counter
    import i2c_seg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_reload_en,
    input  logic             cfg_autostop,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_pec_en,
    input  logic             seg_start,
    input  logic             byte_done,
    input  logic             reload_wr,
    input  logic             cmd_stop,
    output logic             last_byte,
    output logic             nack_next,
    output logic             ack_next,
    output logic             pec_byte,
    output logic             reload_req,
    output logic             xfer_done,
    output logic             stop_req,
    output logic             restart_req,
    output logic             cfg_err
);
    seg_state_e state;
    seg_mode_e  mode_q;
    logic       load, dec, at_one, pec_q, reload_q;

    i2c_seg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_count    (cfg_count),
        .cfg_reload_en(cfg_reload_en),
        .cfg_autostop (cfg_autostop),
        .cfg_mode     (seg_mode_e'(cfg_mode)),
        .cfg_pec_en   (cfg_pec_en),
        .seg_start    (seg_start),
        .byte_done    (byte_done),
        .reload_wr    (reload_wr),
        .cmd_stop     (cmd_stop),
        .at_one       (at_one),
        .state        (state),
        .load         (load),
        .dec          (dec),
        .mode_q       (mode_q),
        .pec_q        (pec_q),
        .reload_q     (reload_q),
        .err_q        (cfg_err),
        .restart_q    (restart_req)
    );

    i2c_seg_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(cfg_count),
        .dec     (dec),
        .at_one  (at_one)
    );

    i2c_seg_flags u_flags (
        .state     (state),
        .at_one    (at_one),
        .mode_q    (mode_q),
        .pec_q     (pec_q),
        .reload_q  (reload_q),
        .last_byte (last_byte),
        .nack_next (nack_next),
        .ack_next  (ack_next),
        .pec_byte  (pec_byte),
        .reload_req(reload_req),
        .xfer_done (xfer_done),
        .stop_req  (stop_req)
    );

    AST_STOP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !xfer_done); // R7
    AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && byte_done) |=> !last_byte); // R2
    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req && !reload_wr) |=> reload_req); // R6
    AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reload_req, xfer_done, last_byte})); // R2

endmodule

// File: tb/test_i2c_seg_counter.sv
module test_i2c_seg_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_count = '0;
    logic       cfg_reload_en = 1'b0, cfg_autostop = 1'b0, cfg_pec_en = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       seg_start = 1'b0, byte_done = 1'b0, reload_wr = 1'b0, cmd_stop = 1'b0;
    logic       last_byte, nack_next, ack_next, pec_byte, reload_req;
    logic       xfer_done, stop_req, restart_req, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_seg_counter i_i2c_seg_counter (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_reload_en(cfg_reload_en),
        .cfg_autostop(cfg_autostop), .cfg_mode(cfg_mode), .cfg_pec_en(cfg_pec_en),
        .seg_start(seg_start), .byte_done(byte_done), .reload_wr(reload_wr),
        .cmd_stop(cmd_stop), .last_byte(last_byte), .nack_next(nack_next),
        .ack_next(ack_next), .pec_byte(pec_byte), .reload_req(reload_req),
        .xfer_done(xfer_done), .stop_req(stop_req), .restart_req(restart_req),
        .cfg_err(cfg_err)
    );

    // fields: [13:12] mode, [11] autostop, [10] pec, [9:2] count, [1:0] end kind
    // end kind: 0 stop cycle, 1 hold, 2 slave end
    localparam logic [13:0] VEC [6] = '{
        {2'd0, 1'b1, 1'b0, 8'd3, 2'd0},
        {2'd1, 1'b1, 1'b1, 8'd4, 2'd0},
        {2'd1, 1'b0, 1'b0, 8'd1, 2'd1},
        {2'd0, 1'b0, 1'b1, 8'd2, 2'd1},
        {2'd3, 1'b1, 1'b1, 8'd3, 2'd2},
        {2'd3, 1'b0, 1'b0, 8'd5, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [1:0] md, input logic [7:0] cnt,
                               input logic rl, input logic as, input logic pec);
        cfg_mode = md; cfg_count = cnt; cfg_reload_en = rl;
        cfg_autostop = as; cfg_pec_en = pec; seg_start = 1'b1;
        @(negedge clk);
        seg_start = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic pulse_reload(input logic [7:0] cnt, input logic rl, input logic with_byte);
        cfg_count = cnt; cfg_reload_en = rl; reload_wr = 1'b1; byte_done = with_byte;
        @(negedge clk);
        reload_wr = 1'b0; byte_done = 1'b0;
    endtask

    task automatic pulse_stop(input logic with_start);
        cmd_stop = 1'b1; seg_start = with_start;
        @(negedge clk);
        cmd_stop = 1'b0; seg_start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {last_byte, nack_next, ack_next, pec_byte, reload_req,
                           xfer_done, stop_req, restart_req, cfg_err}, 0);

        // table walk: R2 R5 R7 R8 R9 R10
        foreach (VEC[v]) begin
            automatic logic [1:0] md  = VEC[v][13:12];
            automatic logic       as  = VEC[v][11];
            automatic logic       pec = VEC[v][10];
            automatic int         n   = int'(VEC[v][9:2]);
            automatic logic [1:0] ek  = VEC[v][1:0];
            pulse_start(md, VEC[v][9:2], 1'b0, as, pec);
            for (int k = 1; k <= n; k++) begin
                automatic logic lastx = (k == n);
                chk("R2 last_byte", last_byte, lastx);
                chk("R5 nack_next", nack_next, lastx && md == 2'd1);
                chk("R10 pec_byte", pec_byte, lastx && pec);
                chk("R9 ack_next", ack_next, md == 2'd3);
                if (k < n) chk("R2 no early done", xfer_done, 0);
                pulse_byte();
            end
            chk("R2 done after N", xfer_done, 1);
            if (ek == 2'd0) begin
                chk("R7 stop_req", stop_req, 1);
                @(negedge clk);
                chk("R7 idle after stop", xfer_done, 0);
            end else if (ek == 2'd1) begin
                chk("R8 no stop in hold", stop_req, 0);
                @(negedge clk);
                chk("R8 hold persists", xfer_done, 1);
                pulse_stop(1'b0);
                chk("R8 stop after cmd", stop_req, 1);
                @(negedge clk);
                chk("R8 idle", xfer_done, 0);
            end else begin
                chk("R9 slave no stop", stop_req, 0);
                @(negedge clk);
                chk("R9 slave ends", xfer_done, 0);
            end
        end

        // R3 zero count start
        pulse_start(2'd0, 8'd0, 1'b0, 1'b1, 1'b0);
        chk("R3 cfg_err pulse", cfg_err, 1);
        chk("R3 no last_byte", last_byte, 0);
        @(negedge clk);
        chk("R3 cfg_err one cycle", cfg_err, 0);
        pulse_byte();
        chk("R3 nothing started", {last_byte, xfer_done, reload_req}, 0);

        // R4 plain slave ignored
        pulse_start(2'd2, 8'd1, 1'b0, 1'b1, 1'b1);
        chk("R4 slave start ignored", {last_byte, cfg_err, pec_byte, ack_next}, 0);
        pulse_byte();
        chk("R4 slave strobe ignored", {xfer_done, stop_req, reload_req}, 0);

        // R6 reload wait, strobes ignored, collision with reload write
        pulse_start(2'd0, 8'd2, 1'b1, 1'b1, 1'b0);
        chk("R6 no last_byte with reload", last_byte, 0);
        pulse_byte();
        pulse_byte();
        chk("R6 reload_req", reload_req, 1);
        pulse_byte();
        chk("R6 strobe ignored", {reload_req, xfer_done}, 2'b10);
        pulse_reload(8'd0, 1'b0, 1'b0);
        chk("R6 zero reload err", {cfg_err, reload_req}, 2'b11);
        pulse_reload(8'd1, 1'b0, 1'b1);
        chk("R6 collision keeps count", {reload_req, last_byte}, 2'b01);
        pulse_byte();
        chk("R6 end after reload", {xfer_done, stop_req}, 2'b11);
        @(negedge clk);

        // R8 stop and restart in same cycle: stop wins
        pulse_start(2'd0, 8'd1, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        chk("R8 hold entered", {xfer_done, stop_req}, 2'b10);
        cfg_count = 8'd3;
        pulse_stop(1'b1);
        chk("R8 stop wins", {stop_req, restart_req}, 2'b10);
        @(negedge clk);
        chk("R8 idle after collision", {xfer_done, last_byte}, 0);

        // R8 restart from hold
        pulse_start(2'd1, 8'd1, 1'b0, 1'b0, 1'b0);
        pulse_byte();
        pulse_start(2'd1, 8'd2, 1'b0, 1'b1, 1'b0);
        chk("R8 restart_req", {restart_req, xfer_done, last_byte}, 3'b100);
        @(negedge clk);
        chk("R8 restart one cycle", restart_req, 0);
        pulse_byte();
        chk("R5 nack after restart", {last_byte, nack_next}, 2'b11);
        pulse_byte();
        chk("R7 stop after restart", {xfer_done, stop_req}, 2'b11);
        @(negedge clk);

        // R6 600-byte transfer in segments
        begin
            automatic int sent = 0;
            automatic int reloads = 0;
            automatic int early = 0;
            pulse_start(2'd0, 8'd255, 1'b1, 1'b1, 1'b0);
            while (sent < 600 && reloads < 5) begin
                if (sent == 599) chk("R2 last of 600", last_byte, 1);
                pulse_byte();
                sent++;
                if (sent < 600 && xfer_done) early++;
                if (reload_req) begin
                    automatic int rem = 600 - sent;
                    reloads++;
                    pulse_reload((rem > 255) ? 8'd255 : 8'(rem), rem > 255, 1'b0);
                end
            end
            chk("R6 no early completion", early, 0);
            chk("R6 two reloads", reloads, 2);
            chk("R6 600 ends with stop", {xfer_done, stop_req}, 2'b11);
            @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule